// File: doc/BRIEF.md
# Bus Error Capture and Status Register

This block collects error events from a bus bridge and holds them for software. Each error class comes in as a one-cycle pulse. Each pulse sets a sticky status bit, and software clears that bit by writing a one to it. The first bus-side error also records the faulting 32-bit bus address and the 4-bit bus command. The first memory read-data error records the upper bits of the system address. After a capture register has logged an error, it stays locked until software clears every status bit that feeds it. An error that finds its register locked sets a lost-error flag and leaves the logged address unchanged.

Two control bits shape the detection. One turns off bus parity checking, so parity error pulses are dropped. The other turns off logging of correctable read-data errors, and it also masks that class from the interrupt. Software reaches three 32-bit words through a single-cycle register port with no back-pressure. A write takes effect at the next clock edge. A read returns the addressed word combinationally in the same cycle. The interrupt output is a level that reflects the status held at that moment.

Top module: `bus_err_csr`

## Requirements
- R1: After reset, every status bit, the lost flag, both control bits and both capture registers are zero, and `irq` is low. Bit 31 of the status word (offset 0) reads the `VERSION_BIT` parameter.
- R2: A pulse on an error input sets its status bit at the next clock edge. The bit stays set until it is cleared. Bit positions in the status word are: 14 invalid map entry, 13 uncorrectable read data, 12 correctable read data, 11 no device, 10 target abort, 9 I/O parity, 8 DMA parity, 6 lost, 5 retry timeout.
- R3: Writing offset 0 clears each status bit (including lost) whose data bit is one and leaves the bits written as zero untouched. If a new error of a class arrives in the same cycle as a clear of that class, the bit ends up set.
- R4: Consider a bus-side error (no device, target abort, I/O parity, DMA parity, invalid map, retry timeout) that arrives while none of those six bits is set. It stores `bus_addr` into offset 1 and `bus_cmd` into status bits 21:18. Bits 21:18 read zero while none of the six bits is set.
- R5: An error that arrives while its capture register is locked sets the lost bit, and the logged address and command stay unchanged.
- R6: When two or more errors of the same register group arrive in one cycle with that register unlocked, the address is logged once and the lost bit is set.
- R7: A read-data error (uncorrectable or correctable) that arrives while bits 13 and 12 are both clear stores `sys_addr[33:6]` into bits 31:4 of offset 2. Bits 3:0 of offset 2 read zero. The register holds while bit 13 or 12 is set.
- R8: When status-word bit 4 (parity check off, read/write) is one, pulses on `ev_io_par` and `ev_dma_par` set no status bit, log no address and set no lost flag.
- R9: When status-word bit 3 (correctable logging off, read/write) is one, `ev_rd_corr` is ignored in the same way, and an already set bit 12 no longer drives `irq`.
- R10: A capture register unlocks once every status bit of its group is cleared. The next error of that group then logs a new address.
- R11: `irq` is high exactly when any status bit or the lost flag is set, leaving out bit 12 while bit 3 is one.
- R12: Bits 30:22, 17:15, 7 and 2:0 of the status word always read zero, and writing them has no effect. Offset 3 reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| csr_addr | input | 2 | Word offset for read and write |
| csr_we | input | 1 | Write strobe, one cycle per write |
| csr_wdata | input | 32 | Write data |
| csr_rdata | output | 32 | Read data for `csr_addr`, combinational |
| ev_no_dev | input | 1 | No target answered a bridge-issued I/O cycle |
| ev_tgt_abort | input | 1 | Target ended an I/O cycle with an abort |
| ev_io_par | input | 1 | Parity error in an I/O data phase |
| ev_dma_par | input | 1 | Parity error in a DMA data phase |
| ev_bad_map | input | 1 | Invalid scatter-gather map entry |
| ev_retry_to | input | 1 | Retry timeout on a processor-issued bus cycle |
| ev_rd_uncorr | input | 1 | Uncorrectable DMA read data |
| ev_rd_corr | input | 1 | Correctable DMA read data |
| bus_addr | input | 32 | Bus address of the current bus-side error |
| bus_cmd | input | 4 | Bus command of the current bus-side error |
| sys_addr | input | 34 | System address of the current read-data error |
| irq | output | 1 | Error interrupt level |

## Verification
The bench first sends each of the eight error classes alone, under all four settings of the two control bits. This separates correct bit placement and address routing from the suppression rules. It then sends every ordered pair of classes in consecutive cycles, which separates the lock-and-lose path from the unlocked capture path and tells the two register groups apart. It also sends all 255 combinations of classes in a single cycle to test the same-cycle loss rule and the group boundaries. Finally, directed sequences cover a clear that coincides with a new error, a partial clear that must keep the lock, and the interrupt mask on an already set correctable bit.

// File: rtl/bec_pkg.sv
package bec_pkg;
  localparam int NUM_EV  = 8;
  localparam int NUM_BUS = 6;
  localparam int NUM_SYS = NUM_EV - NUM_BUS;
  localparam int BUS_AW  = 32;
  localparam int CMD_W   = 4;
  localparam int CSR_AW  = 2;
  localparam int SYS_LSB = 6;
  localparam int SYS_FIELD_LSB = 4;

  // event index order: bus group first, system group last
  localparam int IDX_NO_DEV    = 0;
  localparam int IDX_TGT_ABORT = 1;
  localparam int IDX_IO_PAR    = 2;
  localparam int IDX_DMA_PAR   = 3;
  localparam int IDX_BAD_MAP   = 4;
  localparam int IDX_RETRY_TO  = 5;
  localparam int IDX_RD_UNCORR = 6;
  localparam int IDX_RD_CORR   = 7;

  // status word positions decoded by software
  localparam int VER_POS     = 31;
  localparam int CMD_LSB     = 18;
  localparam int LOST_POS    = 6;
  localparam int PARDIS_POS  = 4;
  localparam int CORRDIS_POS = 3;

  localparam logic [CSR_AW-1:0] OFS_CSR = 2'd0;
  localparam logic [CSR_AW-1:0] OFS_BUS = 2'd1;
  localparam logic [CSR_AW-1:0] OFS_SYS = 2'd2;

  function automatic int stat_pos(input int idx);
    case (idx)
      IDX_NO_DEV:    return 11;
      IDX_TGT_ABORT: return 10;
      IDX_IO_PAR:    return 9;
      IDX_DMA_PAR:   return 8;
      IDX_BAD_MAP:   return 14;
      IDX_RETRY_TO:  return 5;
      IDX_RD_UNCORR: return 13;
      default:       return 12;
    endcase
  endfunction
endpackage

// File: rtl/bec_status.sv
module bec_status #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  input  logic         lost_set_i,
  input  logic         lost_clr_i,
  output logic [N-1:0] stat_o,
  output logic         lost_o
);
  for (genvar g = 0; g < N; g++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          stat_o[g] <= 1'b0;
      else if (set_i[g])   stat_o[g] <= 1'b1;
      else if (clr_i[g])   stat_o[g] <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          lost_o <= 1'b0;
    else if (lost_set_i) lost_o <= 1'b1;
    else if (lost_clr_i) lost_o <= 1'b0;
  end
endmodule

// File: rtl/bec_lock_ctl.sv
module bec_lock_ctl #(
  parameter int N = 6
) (
  input  logic [N-1:0] ev_i,
  input  logic         locked_i,
  output logic         cap_o,
  output logic         lost_o
);
  logic any_ev;
  logic multi_ev;

  assign any_ev   = |ev_i;
  assign multi_ev = |(ev_i & (ev_i - 1'b1));
  assign cap_o    = any_ev & ~locked_i;
  assign lost_o   = any_ev & (locked_i | multi_ev);
endmodule

// File: rtl/bec_capture.sv
module bec_capture #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cap_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     q_o <= '0;
    else if (cap_i) q_o <= d_i;
  end
endmodule

// File: rtl/bus_err_csr.sv
module bus_err_csr
  import bec_pkg::*;
#(
  parameter logic VERSION_BIT = 1'b1,
  parameter int   SYS_AW      = 34
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CSR_AW-1:0] csr_addr,
  input  logic              csr_we,
  input  logic [31:0]       csr_wdata,
  output logic [31:0]       csr_rdata,
  input  logic              ev_no_dev,
  input  logic              ev_tgt_abort,
  input  logic              ev_io_par,
  input  logic              ev_dma_par,
  input  logic              ev_bad_map,
  input  logic              ev_retry_to,
  input  logic              ev_rd_uncorr,
  input  logic              ev_rd_corr,
  input  logic [BUS_AW-1:0] bus_addr,
  input  logic [CMD_W-1:0]  bus_cmd,
  input  logic [SYS_AW-1:0] sys_addr,
  output logic              irq
);
  localparam int SLOG_W = SYS_AW - SYS_LSB;
  localparam int BLOG_W = BUS_AW + CMD_W;

  logic              cfg_par_dis;
  logic              cfg_corr_dis;
  logic [NUM_EV-1:0] ev_raw;
  logic [NUM_EV-1:0] ev_ign;
  logic [NUM_EV-1:0] ev_ok;
  logic [NUM_EV-1:0] clr_mask;
  logic [NUM_EV-1:0] irq_mask;
  logic [NUM_EV-1:0] stat_q;
  logic              lost_q;
  logic              wr_csr;
  logic              bus_locked, sys_locked;
  logic              bus_cap, sys_cap;
  logic              bus_lost, sys_lost;
  logic [BLOG_W-1:0] bus_log_q;
  logic [SLOG_W-1:0] sys_log_q;
  logic [31:0]       csr_word;
  logic [31:0]       sys_word;
  logic              unused_bits;

  assign unused_bits = ^{csr_wdata, sys_addr[SYS_LSB-1:0]};
  assign wr_csr = csr_we & (csr_addr == OFS_CSR);

  // control bits
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_par_dis  <= 1'b0;
      cfg_corr_dis <= 1'b0;
    end else if (wr_csr) begin
      cfg_par_dis  <= csr_wdata[PARDIS_POS];
      cfg_corr_dis <= csr_wdata[CORRDIS_POS];
    end
  end

  // event gathering and suppression
  always_comb begin
    ev_raw = '0;
    ev_raw[IDX_NO_DEV]    = ev_no_dev;
    ev_raw[IDX_TGT_ABORT] = ev_tgt_abort;
    ev_raw[IDX_IO_PAR]    = ev_io_par;
    ev_raw[IDX_DMA_PAR]   = ev_dma_par;
    ev_raw[IDX_BAD_MAP]   = ev_bad_map;
    ev_raw[IDX_RETRY_TO]  = ev_retry_to;
    ev_raw[IDX_RD_UNCORR] = ev_rd_uncorr;
    ev_raw[IDX_RD_CORR]   = ev_rd_corr;
    ev_ign = '0;
    ev_ign[IDX_IO_PAR]  = cfg_par_dis;
    ev_ign[IDX_DMA_PAR] = cfg_par_dis;
    ev_ign[IDX_RD_CORR] = cfg_corr_dis;
    irq_mask = '0;
    irq_mask[IDX_RD_CORR] = cfg_corr_dis;
  end

  assign ev_ok = ev_raw & ~ev_ign;

  for (genvar g = 0; g < NUM_EV; g++) begin : g_clr
    assign clr_mask[g] = wr_csr & csr_wdata[stat_pos(g)];
  end

  assign bus_locked = |stat_q[NUM_BUS-1:0];
  assign sys_locked = |stat_q[NUM_EV-1:NUM_BUS];

  bec_lock_ctl #(.N(NUM_BUS)) u_bus_lock (
    .ev_i     (ev_ok[NUM_BUS-1:0]),
    .locked_i (bus_locked),
    .cap_o    (bus_cap),
    .lost_o   (bus_lost)
  );

  bec_lock_ctl #(.N(NUM_SYS)) u_sys_lock (
    .ev_i     (ev_ok[NUM_EV-1:NUM_BUS]),
    .locked_i (sys_locked),
    .cap_o    (sys_cap),
    .lost_o   (sys_lost)
  );

  bec_capture #(.W(BLOG_W)) u_bus_log (
    .clk   (clk),
    .rst_n (rst_n),
    .cap_i (bus_cap),
    .d_i   ({bus_cmd, bus_addr}),
    .q_o   (bus_log_q)
  );

  bec_capture #(.W(SLOG_W)) u_sys_log (
    .clk   (clk),
    .rst_n (rst_n),
    .cap_i (sys_cap),
    .d_i   (sys_addr[SYS_AW-1:SYS_LSB]),
    .q_o   (sys_log_q)
  );

  bec_status #(.N(NUM_EV)) u_status (
    .clk        (clk),
    .rst_n      (rst_n),
    .set_i      (ev_ok),
    .clr_i      (clr_mask),
    .lost_set_i (bus_lost | sys_lost),
    .lost_clr_i (wr_csr & csr_wdata[LOST_POS]),
    .stat_o     (stat_q),
    .lost_o     (lost_q)
  );

  // read words
  always_comb begin
    csr_word = '0;
    csr_word[VER_POS] = VERSION_BIT;
    if (bus_locked) csr_word[CMD_LSB +: CMD_W] = bus_log_q[BUS_AW +: CMD_W];
    for (int i = 0; i < NUM_EV; i++) csr_word[stat_pos(i)] = stat_q[i];
    csr_word[LOST_POS]    = lost_q;
    csr_word[PARDIS_POS]  = cfg_par_dis;
    csr_word[CORRDIS_POS] = cfg_corr_dis;
    sys_word = '0;
    sys_word[SYS_FIELD_LSB +: SLOG_W] = sys_log_q;
  end

  always_comb begin
    case (csr_addr)
      OFS_CSR: csr_rdata = csr_word;
      OFS_BUS: csr_rdata = bus_log_q[BUS_AW-1:0];
      OFS_SYS: csr_rdata = sys_word;
      default: csr_rdata = '0;
    endcase
  end

  assign irq = (|(stat_q & ~irq_mask)) | lost_q;
endmodule

// File: rtl/bec_checker.sv
module bec_checker (
  input logic        clk,
  input logic        rst_n,
  input logic [1:0]  csr_addr,
  input logic [31:0] csr_rdata,
  input logic [7:0]  stat_q,
  input logic        lost_q,
  input logic        cfg_par_dis,
  input logic        cfg_corr_dis,
  input logic        bus_locked,
  input logic        sys_locked,
  input logic [35:0] bus_log_q,
  input logic [27:0] sys_log_q,
  input logic        ev_no_dev,
  input logic        ev_tgt_abort,
  input logic        ev_bad_map,
  input logic        ev_retry_to,
  input logic        ev_rd_uncorr,
  input logic        irq
);
  assert_sticky_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ev_no_dev |=> stat_q[0]);

  assert_bus_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    bus_locked |=> $stable(bus_log_q));

  assert_lost_locked_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_locked && (ev_no_dev || ev_tgt_abort || ev_bad_map || ev_retry_to)) |=> lost_q);

  assert_sys_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    sys_locked |=> $stable(sys_log_q));

  assert_sys_lost_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (sys_locked && ev_rd_uncorr) |=> lost_q);

  assert_io_par_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_par_dis && !stat_q[2]) |=> !stat_q[2]);

  assert_dma_par_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_par_dis && !stat_q[3]) |=> !stat_q[3]);

  assert_corr_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_corr_dis && !stat_q[7]) |=> !stat_q[7]);

  assert_irq_high_R11: assert property (@(posedge clk) disable iff (!rst_n)
    ((|stat_q[6:0]) || lost_q) |-> irq);

  assert_irq_low_R11: assert property (@(posedge clk) disable iff (!rst_n)
    ((stat_q == 8'h00) && !lost_q) |-> !irq);

  assert_reserved_zero_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_addr == 2'd0) |-> (csr_rdata[30:22] == 9'h0 && csr_rdata[17:15] == 3'h0 &&
                            !csr_rdata[7] && csr_rdata[2:0] == 3'h0));
endmodule

bind bus_err_csr bec_checker u_bec_checker (
  .clk          (clk),
  .rst_n        (rst_n),
  .csr_addr     (csr_addr),
  .csr_rdata    (csr_rdata),
  .stat_q       (stat_q),
  .lost_q       (lost_q),
  .cfg_par_dis  (cfg_par_dis),
  .cfg_corr_dis (cfg_corr_dis),
  .bus_locked   (bus_locked),
  .sys_locked   (sys_locked),
  .bus_log_q    (bus_log_q),
  .sys_log_q    (sys_log_q),
  .ev_no_dev    (ev_no_dev),
  .ev_tgt_abort (ev_tgt_abort),
  .ev_bad_map   (ev_bad_map),
  .ev_retry_to  (ev_retry_to),
  .ev_rd_uncorr (ev_rd_uncorr),
  .irq          (irq)
);

// File: tb/bus_err_csr_bench.sv
module bus_err_csr_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  csr_addr = '0;
  logic        csr_we = 1'b0;
  logic [31:0] csr_wdata = '0;
  logic [31:0] csr_rdata;
  logic [7:0]  ev = '0;
  logic [31:0] bus_addr = '0;
  logic [3:0]  bus_cmd = '0;
  logic [33:0] sys_addr = '0;
  logic        irq;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  bit done = 1'b0;

  // reference state built from the requirements
  logic [7:0]  m_stat = '0;
  logic        m_lost = 1'b0;
  logic [31:0] m_bus = '0;
  logic [3:0]  m_cmd = '0;
  logic [27:0] m_sys = '0;
  logic        m_par = 1'b0;
  logic        m_corr = 1'b0;

  always #5 clk = ~clk;

  bus_err_csr u_bus_err_csr (
    .clk (clk), .rst_n (rst_n),
    .csr_addr (csr_addr), .csr_we (csr_we), .csr_wdata (csr_wdata), .csr_rdata (csr_rdata),
    .ev_no_dev (ev[0]), .ev_tgt_abort (ev[1]), .ev_io_par (ev[2]), .ev_dma_par (ev[3]),
    .ev_bad_map (ev[4]), .ev_retry_to (ev[5]), .ev_rd_uncorr (ev[6]), .ev_rd_corr (ev[7]),
    .bus_addr (bus_addr), .bus_cmd (bus_cmd), .sys_addr (sys_addr), .irq (irq)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles == 150000 && !done) begin
      failures++;
      $display("FAIL watchdog: run did not finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  // status word positions per R2
  function automatic int bpos(input int i);
    case (i)
      0: return 11; 1: return 10; 2: return 9; 3: return 8;
      4: return 14; 5: return 5;  6: return 13; default: return 12;
    endcase
  endfunction

  function automatic logic [31:0] exp_csr();
    logic [31:0] w;
    w = 32'h8000_0000;
    if (|m_stat[5:0]) w[21:18] = m_cmd;
    for (int i = 0; i < 8; i++) w[bpos(i)] = m_stat[i];
    w[6] = m_lost;
    w[4] = m_par;
    w[3] = m_corr;
    return w;
  endfunction

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic check_all(input string tag);
    csr_addr = 2'd0; #1;
    chk(tag, "status", csr_rdata, exp_csr());
    csr_addr = 2'd1; #1;
    chk(tag, "bus addr", csr_rdata, m_bus);
    csr_addr = 2'd2; #1;
    chk(tag, "sys addr", csr_rdata, {m_sys, 4'h0});
    chk(tag, "irq", {31'h0, irq}, {31'h0, (|m_stat[6:0]) | m_lost | (m_stat[7] & ~m_corr)});
    csr_addr = 2'd0;
  endtask

  task automatic step(input logic [7:0] e, input logic [31:0] ba, input logic [33:0] sa,
                      input logic [3:0] cmd, input logic we, input logic [1:0] wa,
                      input logic [31:0] wd);
    logic [7:0] g, clr;
    logic bl, sl, nl, lc;
    g = e;
    if (m_par) g[3:2] = 2'b00;
    if (m_corr) g[7] = 1'b0;
    bl = |m_stat[5:0];
    sl = |m_stat[7:6];
    nl = 1'b0;
    if (|g[5:0]) begin
      if (!bl) begin m_bus = ba; m_cmd = cmd; end
      if (bl || $countones(g[5:0]) > 1) nl = 1'b1;
    end
    if (|g[7:6]) begin
      if (!sl) m_sys = sa[33:6];
      if (sl || g[7:6] == 2'b11) nl = 1'b1;
    end
    clr = '0;
    lc = 1'b0;
    if (we && wa == 2'd0) begin
      for (int i = 0; i < 8; i++) clr[i] = wd[bpos(i)];
      lc = wd[6];
    end
    m_stat = (m_stat & ~clr) | g;
    m_lost = (m_lost & ~lc) | nl;
    if (we && wa == 2'd0) begin m_par = wd[4]; m_corr = wd[3]; end
    @(negedge clk);
    ev = e; bus_addr = ba; sys_addr = sa; bus_cmd = cmd;
    csr_we = we; csr_addr = wa; csr_wdata = wd;
    @(negedge clk);
    ev = '0; csr_we = 1'b0; csr_addr = 2'd0;
  endtask

  task automatic clear_all(input logic [1:0] cfg);
    step(8'h00, 32'h0, 34'h0, 4'h0, 1'b1, 2'd0, 32'h0000_7F60 | {27'h0, cfg, 3'b000});
  endtask

  function automatic logic [31:0] baddr_of(input int k);
    return 32'hA500_0000 ^ (k * 32'h0101_0101) ^ {k[7:0], 24'h00_5A3C};
  endfunction

  function automatic logic [33:0] saddr_of(input int k);
    return {2'b10, 32'h0} ^ (k * 34'h0_0357_0FC1) ^ {8'h0, k[7:0], 18'h2A5A5};
  endfunction

  initial begin
    #1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state
    check_all("R1");

    // R4 R7 R8 R9: each class alone under every control setting
    for (int cfg = 0; cfg < 4; cfg++) begin
      for (int i = 0; i < 8; i++) begin
        string tag;
        clear_all(cfg[1:0]);
        tag = (i < 6) ? "R4" : "R7";
        if ((i == 2 || i == 3) && cfg[1]) tag = "R8";
        if (i == 7 && cfg[0]) tag = "R9";
        step(8'h1 << i, baddr_of(cfg * 8 + i), saddr_of(cfg * 8 + i), 4'(i + cfg),
             1'b0, 2'd0, 32'h0);
        check_all(tag);
        // R2: stays set with no further input
        step(8'h00, 32'h0, 34'h0, 4'h0, 1'b0, 2'd0, 32'h0);
        check_all("R2");
      end
    end

    // R5: every ordered pair in consecutive cycles
    for (int i = 0; i < 8; i++) begin
      for (int j = 0; j < 8; j++) begin
        clear_all(2'b00);
        step(8'h1 << i, baddr_of(i), saddr_of(i), 4'(i), 1'b0, 2'd0, 32'h0);
        step(8'h1 << j, baddr_of(j + 40), saddr_of(j + 40), 4'(j + 7), 1'b0, 2'd0, 32'h0);
        check_all("R5");
      end
    end

    // R6: every same-cycle combination
    for (int m = 1; m < 256; m++) begin
      clear_all(m[1:0]);
      step(m[7:0], baddr_of(m), saddr_of(m), m[3:0], 1'b0, 2'd0, 32'h0);
      check_all("R6");
    end

    // R3: clear and new error of the same class in one cycle
    clear_all(2'b00);
    step(8'h01, 32'h1111_0000, 34'h0, 4'h3, 1'b0, 2'd0, 32'h0);
    step(8'h01, 32'h2222_0000, 34'h0, 4'h5, 1'b1, 2'd0, 32'h0000_0800);
    check_all("R3");
    // R3: clearing lost only, written zeros leave bit 11
    step(8'h00, 32'h0, 34'h0, 4'h0, 1'b1, 2'd0, 32'h0000_0040);
    check_all("R3");

    // R10: partial clear keeps the lock, full clear releases it
    clear_all(2'b00);
    step(8'h01, 32'hC0DE_0001, 34'h0, 4'h1, 1'b0, 2'd0, 32'h0);
    step(8'h20, 32'hC0DE_0002, 34'h0, 4'h2, 1'b0, 2'd0, 32'h0);
    step(8'h00, 32'h0, 34'h0, 4'h0, 1'b1, 2'd0, 32'h0000_0840);
    step(8'h02, 32'hC0DE_0003, 34'h0, 4'h3, 1'b0, 2'd0, 32'h0);
    check_all("R10");
    clear_all(2'b00);
    step(8'h02, 32'hC0DE_0004, 34'h0, 4'h4, 1'b0, 2'd0, 32'h0);
    check_all("R10");

    // R11 R9: set correctable bit, then mask it from the interrupt
    clear_all(2'b00);
    step(8'h80, 32'h0, 34'h3_1234_5678, 4'h0, 1'b0, 2'd0, 32'h0);
    check_all("R11");
    step(8'h00, 32'h0, 34'h0, 4'h0, 1'b1, 2'd0, 32'h0000_0008);
    check_all("R9");

    // R12: writing all ones touches only writable bits; offset 3 reads zero
    clear_all(2'b00);
    step(8'h10, 32'h7777_0000, 34'h0, 4'h9, 1'b0, 2'd0, 32'h0);
    step(8'h00, 32'h0, 34'h0, 4'h0, 1'b1, 2'd0, 32'hFFFF_FFFF);
    check_all("R12");
    csr_addr = 2'd3; #1;
    chk("R12", "offset 3", csr_rdata, 32'h0);
    csr_addr = 2'd0;

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule